// File: doc/BRIEF.md
# Layered Overlay Compositor

This block merges three pixel layers into one output stream over a programmable background colour. Layer 0 is a graphics layer; layers 1 and 2 are video layers. All inputs arrive already aligned, one pixel per clock. A per-layer valid flag marks pixels that fall outside that layer's window. Every pixel is ARGB with 12-bit components: A in bits [47:36], R in [35:24], G in [23:12] and B in [11:0]. Layer i occupies `lay_pix[48*i +: 48]`, and every per-layer field is packed the same way, by layer index.

Each layer has its own settings:
- enable
- 2-bit stacking code
- 12-bit global alpha
- 2-bit alpha mode
- premultiplied flag

A source colour key can make graphics pixels transparent. A destination colour key can restrict upper layers to places where the composite beneath them matches a key colour. The output alpha only matters when the result goes back to memory; a display path discards it. A shared stacking code raises a configuration error flag.

The datapath has four register stages: one selection stage and one blend stage per stacking slot. The valid flag and a sideband vector travel with the pixel. Configuration is held stable while pixels are in flight.

Top module: `layer_compositor`

## Requirements
- R1: `out_valid` and `out_sb` equal `in_valid` and `in_sb` as sampled four clock edges earlier. When valid, `out_argb` is the composite of the layer, background and key inputs sampled at that same edge.
- R2: While reset is asserted, `out_valid` is 0 and `out_argb` is 0.
- R3: A layer with stacking code 0 is blended directly onto the background and code 2 ends on top, with slots processed from code 0 upward. Code 3 leaves the layer out. Any permutation of codes 0..2 is accepted.
- R4: When several layers hold the same code, only the lowest-index one fills that slot and the others are not composited. `cfg_err` is high, combinationally, whenever any two layers share a code, 3 included.
- R5: In the alpha calculation, alpha 4095 is treated as 4096/4096 (fully opaque) and any other value v as v/4096. The mode codes are:
  - 00: use the global alpha G'.
  - 01: use the pixel alpha P'.
  - 10 and 11: use the product (G'·P' + 2048) >> 12.
- R6: Each colour channel becomes min(4095, (f·src + (4096−a)·dst + 2048) >> 12). Here a is the effective alpha and f = a for a non-premultiplied layer. The alpha channel becomes (a·4095 + (4096−a)·dst_alpha + 2048) >> 12.
- R7: For a premultiplied layer, f is 4096 in mode 01 and G' in the other modes.
- R8: A layer whose enable or valid bit is 0 leaves the composite unchanged.
- R9: With `srckey_en` set, a graphics pixel whose RGB equals `srckey_rgb` is fully transparent. The key never applies to the video layers.
- R10: With `dstkey_en` set, a layer is blended only where the composite RGB below it equals `dstkey_rgb`; elsewhere that slot is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel slot valid |
| in_sb | input | SBW | Sideband flags delayed with the pixel |
| lay_pix | input | NL*48 | ARGB pixel per layer |
| lay_vld | input | NL | Layer pixel inside its window |
| lay_en | input | NL | Layer enable |
| lay_z | input | NL*ZW | Stacking code per layer |
| lay_galpha | input | NL*12 | Global alpha per layer |
| lay_amode | input | NL*2 | Alpha mode per layer |
| lay_premul | input | NL | Premultiplied input per layer |
| bg_argb | input | 48 | Background colour |
| srckey_en | input | 1 | Source key enable (graphics layer) |
| srckey_rgb | input | 36 | Source key colour |
| dstkey_en | input | 1 | Destination key enable |
| dstkey_rgb | input | 36 | Destination key colour |
| out_valid | output | 1 | Output pixel valid |
| out_sb | output | SBW | Delayed sideband |
| out_argb | output | 48 | Composited ARGB pixel |
| cfg_err | output | 1 | Duplicate stacking code |

## Verification
The bench runs every permutation of stacking codes with opaque layers; a design that mixed up slot order would show the wrong layer on top. It drives duplicate codes and hidden layers; a wrong tie-break would let the higher-index layer through or leave `cfg_err` low. Alpha values of 0 and 4095 are forced often, so a design without the opaque expansion would leak about 1/4096 of the lower colour and fail exact matches. Premultiplied pixels whose colour exceeds their alpha check the clamp. Key-matching pixels are injected on purpose, and a key applied to the wrong layer or to the wrong composite would show up as mismatches.

// File: rtl/layer_compositor.sv
module layer_compositor #(
  parameter int CW  = 12,
  parameter int NL  = 3,
  parameter int SBW = 2,
  localparam int PW = 4 * CW,
  localparam int ZW = $clog2(NL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SBW-1:0]    in_sb,
  input  logic [NL*PW-1:0]  lay_pix,
  input  logic [NL-1:0]     lay_vld,
  input  logic [NL-1:0]     lay_en,
  input  logic [NL*ZW-1:0]  lay_z,
  input  logic [NL*CW-1:0]  lay_galpha,
  input  logic [NL*2-1:0]   lay_amode,
  input  logic [NL-1:0]     lay_premul,
  input  logic [PW-1:0]     bg_argb,
  input  logic              srckey_en,
  input  logic [3*CW-1:0]   srckey_rgb,
  input  logic              dstkey_en,
  input  logic [3*CW-1:0]   dstkey_rgb,
  output logic              out_valid,
  output logic [SBW-1:0]    out_sb,
  output logic [PW-1:0]     out_argb,
  output logic              cfg_err
);
  localparam int AW   = CW + 1;
  localparam int TW   = 2 * CW + 3;
  localparam int ONE  = 1 << CW;
  localparam int FULL = ONE - 1;
  localparam int HALF = 1 << (CW - 1);

  function automatic logic [AW-1:0] expand(input logic [CW-1:0] v);
    return (v == {CW{1'b1}}) ? AW'(ONE) : {1'b0, v};
  endfunction

  function automatic logic [PW-1:0] mix(input logic [PW-1:0] d, input logic [PW-1:0] s,
                                         input logic [AW-1:0] a, input logic [AW-1:0] f);
    logic [TW-1:0] t;
    logic [PW-1:0] r;
    for (int c = 0; c < 3; c++) begin
      t = TW'(f) * TW'(s[c*CW +: CW]) + TW'(AW'(ONE) - a) * TW'(d[c*CW +: CW]) + TW'(HALF);
      r[c*CW +: CW] = (t[TW-1:2*CW] != '0) ? {CW{1'b1}} : t[CW +: CW];
    end
    t = TW'(a) * TW'(FULL) + TW'(AW'(ONE) - a) * TW'(d[PW-1 -: CW]) + TW'(HALF);
    r[PW-1 -: CW] = t[CW +: CW];
    return r;
  endfunction

  // slot selection and alpha preparation
  logic [PW-1:0] s_pix [NL];
  logic          s_act [NL];
  logic [AW-1:0] s_a   [NL];
  logic [AW-1:0] s_f   [NL];

  always_comb begin
    for (int s = 0; s < NL; s++) begin
      int            sel;
      logic          hit;
      logic [AW-1:0] ga, pa;
      logic [TW-1:0] prod;
      logic [1:0]    am;
      sel = 0;
      hit = 1'b0;
      for (int i = NL - 1; i >= 0; i--)
        if (lay_z[i*ZW +: ZW] == ZW'(s)) begin
          hit = 1'b1;
          sel = i;
        end
      s_pix[s] = lay_pix[sel*PW +: PW];
      ga   = expand(lay_galpha[sel*CW +: CW]);
      pa   = expand(s_pix[s][PW-1 -: CW]);
      prod = TW'(ga) * TW'(pa) + TW'(HALF);
      am   = lay_amode[sel*2 +: 2];
      s_a[s] = am[1] ? prod[CW +: AW] : (am[0] ? pa : ga);
      s_f[s] = lay_premul[sel] ? ((am == 2'b01) ? AW'(ONE) : ga) : s_a[s];
      s_act[s] = hit && lay_en[sel] && lay_vld[sel] &&
                 !(sel == 0 && srckey_en && s_pix[s][3*CW-1:0] == srckey_rgb);
    end
  end

  always_comb begin
    logic [(1<<ZW)-1:0] used;
    used    = '0;
    cfg_err = 1'b0;
    for (int i = 0; i < NL; i++) begin
      if (used[lay_z[i*ZW +: ZW]]) cfg_err = 1'b1;
      used[lay_z[i*ZW +: ZW]] = 1'b1;
    end
  end

  // stage 0 captures, stage k blends slot k-1
  logic [PW-1:0]  acc_q [NL+1];
  logic           v_q   [NL+1];
  logic [SBW-1:0] sb_q  [NL+1];
  logic [PW-1:0]  p_q   [NL][NL];
  logic           act_q [NL][NL];
  logic [AW-1:0]  a_q   [NL][NL];
  logic [AW-1:0]  f_q   [NL][NL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= NL; k++) begin
        acc_q[k] <= '0;
        v_q[k]   <= 1'b0;
        sb_q[k]  <= '0;
      end
      for (int k = 0; k < NL; k++)
        for (int s = 0; s < NL; s++) begin
          p_q[k][s]   <= '0;
          act_q[k][s] <= 1'b0;
          a_q[k][s]   <= '0;
          f_q[k][s]   <= '0;
        end
    end else begin
      acc_q[0] <= bg_argb;
      v_q[0]   <= in_valid;
      sb_q[0]  <= in_sb;
      for (int s = 0; s < NL; s++) begin
        p_q[0][s]   <= s_pix[s];
        act_q[0][s] <= s_act[s];
        a_q[0][s]   <= s_a[s];
        f_q[0][s]   <= s_f[s];
      end
      for (int k = 1; k <= NL; k++) begin
        v_q[k]  <= v_q[k-1];
        sb_q[k] <= sb_q[k-1];
        if (act_q[k-1][k-1] && (!dstkey_en || acc_q[k-1][3*CW-1:0] == dstkey_rgb))
          acc_q[k] <= mix(acc_q[k-1], p_q[k-1][k-1], a_q[k-1][k-1], f_q[k-1][k-1]);
        else
          acc_q[k] <= acc_q[k-1];
        if (k < NL)
          for (int s = 0; s < NL; s++) begin
            p_q[k][s]   <= p_q[k-1][s];
            act_q[k][s] <= act_q[k-1][s];
            a_q[k][s]   <= a_q[k-1][s];
            f_q[k][s]   <= f_q[k-1][s];
          end
      end
    end
  end

  assign out_valid = v_q[NL];
  assign out_sb    = sb_q[NL];
  assign out_argb  = acc_q[NL];
endmodule

// File: rtl/layer_compositor_chk.sv
module layer_compositor_chk #(
  parameter int NL  = 3,
  parameter int SBW = 2,
  parameter int PW  = 48,
  parameter int ZW  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [SBW-1:0]    in_sb,
  input logic [NL-1:0]     lay_en,
  input logic [NL-1:0]     lay_vld,
  input logic [NL*ZW-1:0]  lay_z,
  input logic [PW-1:0]     bg_argb,
  input logic              out_valid,
  input logic [SBW-1:0]    out_sb,
  input logic [PW-1:0]     out_argb,
  input logic              cfg_err
);
  logic [2:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd4) cnt <= cnt + 3'd1;

  function automatic logic dup(input logic [NL*ZW-1:0] z);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NL; i++)
      for (int j = i + 1; j < NL; j++)
        if (z[i*ZW +: ZW] == z[j*ZW +: ZW]) r = 1'b1;
    return r;
  endfunction

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == 3'd4 |-> out_valid == $past(in_valid, 4));  // R1
  AST_SB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 3'd4 && out_valid) |-> out_sb == $past(in_sb, 4));  // R1
  AST_DUP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err == dup(lay_z));  // R4
  AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 3'd4 && out_valid && $past(lay_en & lay_vld, 4) == '0) |-> out_argb == $past(bg_argb, 4));  // R8
endmodule

bind layer_compositor layer_compositor_chk #(.NL(NL), .SBW(SBW), .PW(PW), .ZW(ZW)) u_chk (.*);

// File: tb/layer_compositor_tb_top.sv
module layer_compositor_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_sb;
  logic [143:0] lay_pix;
  logic [2:0]   lay_vld, lay_en, lay_premul;
  logic [5:0]   lay_z, lay_amode;
  logic [35:0]  lay_galpha;
  logic [47:0]  bg_argb;
  logic         srckey_en, dstkey_en;
  logic [35:0]  srckey_rgb, dstkey_rgb;
  logic         out_valid, cfg_err;
  logic [1:0]   out_sb;
  logic [47:0]  out_argb;

  layer_compositor dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sb(in_sb),
    .lay_pix(lay_pix), .lay_vld(lay_vld), .lay_en(lay_en), .lay_z(lay_z),
    .lay_galpha(lay_galpha), .lay_amode(lay_amode), .lay_premul(lay_premul),
    .bg_argb(bg_argb), .srckey_en(srckey_en), .srckey_rgb(srckey_rgb),
    .dstkey_en(dstkey_en), .dstkey_rgb(dstkey_rgb),
    .out_valid(out_valid), .out_sb(out_sb), .out_argb(out_argb), .cfg_err(cfg_err));

  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R6";
  logic [47:0] e_pix [8];
  logic        e_v   [8];
  logic [1:0]  e_sb  [8];
  string       e_tag [8];

  function automatic int ex(int v);
    return (v == 4095) ? 4096 : v;
  endfunction

  function automatic logic [47:0] model();
    logic [47:0] acc, nxt, p;
    int li, g, pa, m, a, f;
    longint v;
    acc = bg_argb;
    for (int s = 0; s < 3; s++) begin
      li = -1;
      for (int i = 2; i >= 0; i--) if (lay_z[2*i +: 2] == 2'(s)) li = i;
      if (li >= 0) begin
        p = lay_pix[48*li +: 48];
        if (lay_en[li] && lay_vld[li] && !(li == 0 && srckey_en && p[35:0] == srckey_rgb) &&
            (!dstkey_en || acc[35:0] == dstkey_rgb)) begin
          g  = ex(int'(lay_galpha[12*li +: 12]));
          pa = ex(int'(p[47:36]));
          m  = int'(lay_amode[2*li +: 2]);
          a  = (m >= 2) ? (g * pa + 2048) / 4096 : (m == 1 ? pa : g);
          f  = lay_premul[li] ? (m == 1 ? 4096 : g) : a;
          for (int c = 0; c < 3; c++) begin
            v = (longint'(f) * p[c*12 +: 12] + longint'(4096 - a) * acc[c*12 +: 12] + 2048) / 4096;
            if (v > 4095) v = 4095;
            nxt[c*12 +: 12] = v[11:0];
          end
          v = (longint'(a) * 4095 + longint'(4096 - a) * acc[47:36] + 2048) / 4096;
          nxt[47:36] = v[11:0];
          acc = nxt;
        end
      end
    end
    return acc;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    int k;
    @(negedge clk);
    cyc++;
    k = cyc % 8;
    chk("R1 out_valid", 64'(out_valid), 64'(e_v[k]));
    if (e_v[k]) begin
      chk({e_tag[k], " out_argb"}, 64'(out_argb), 64'(e_pix[k]));
      chk("R1 out_sb", 64'(out_sb), 64'(e_sb[k]));
    end
  endtask

  task automatic issue();
    int k;
    k = (cyc + 4) % 8;
    e_pix[k] = model();
    e_v[k]   = in_valid;
    e_sb[k]  = in_sb;
    e_tag[k] = cur_tag;
    tick();
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (4) issue();
  endtask

  function automatic logic [11:0] pick_alpha();
    int r;
    r = $urandom % 4;
    return (r == 0) ? 12'd0 : (r == 1) ? 12'hFFF : 12'($urandom);
  endfunction

  task automatic rand_pix();
    for (int i = 0; i < 3; i++) begin
      lay_pix[48*i +: 48] = {pick_alpha(), 4'($urandom), 32'($urandom)};
      if ($urandom % 4 == 0) lay_pix[48*i +: 36] = srckey_rgb;
    end
    bg_argb  = {pick_alpha(), 4'($urandom), 32'($urandom)};
    if ($urandom % 2 == 0) bg_argb[35:0] = dstkey_rgb;
    lay_vld  = 3'($urandom) | 3'($urandom);
    in_valid = ($urandom % 5) != 0;
    in_sb    = 2'($urandom);
  endtask

  task automatic set_perm();
    int p0, p1;
    p0 = $urandom % 3;
    p1 = (p0 + 1 + $urandom % 2) % 3;
    lay_z = {2'(3 - p0 - p1), 2'(p1), 2'(p0)};
  endtask

  task automatic rand_cfg();
    lay_en = 3'($urandom) | 3'($urandom);
    set_perm();
    if ($urandom % 6 == 0) lay_z[2*($urandom % 3) +: 2] = 2'($urandom);
    for (int i = 0; i < 3; i++) lay_galpha[12*i +: 12] = pick_alpha();
    lay_amode  = 6'($urandom);
    lay_premul = 3'($urandom);
    srckey_en  = 1'($urandom);
    dstkey_en  = ($urandom % 3) == 0;
    srckey_rgb = {4'($urandom), 32'($urandom)};
    dstkey_rgb = {4'($urandom), 32'($urandom)};
  endtask

  task automatic run(string tag, int n);
    cur_tag = tag;
    repeat (n) begin
      rand_pix();
      issue();
    end
    drain();
  endtask

  task automatic base_cfg();
    rand_cfg();
    lay_en = 3'b111; lay_premul = 3'b000; srckey_en = 1'b0; dstkey_en = 1'b0;
    set_perm();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20201228));
    for (int k = 0; k < 8; k++) begin e_v[k] = 1'b0; e_pix[k] = '0; e_sb[k] = '0; e_tag[k] = "R1"; end
    rst_n = 1'b0; in_valid = 1'b0; in_sb = '0; lay_pix = '0; lay_vld = '0; lay_en = '0;
    lay_z = '0; lay_galpha = '0; lay_amode = '0; lay_premul = '0; bg_argb = '0;
    srckey_en = 1'b0; dstkey_en = 1'b0; srckey_rgb = '0; dstkey_rgb = '0;
    repeat (3) @(negedge clk);
    chk("R2 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R2 out_argb in reset", 64'(out_argb), 64'd0);
    rst_n = 1'b1;

    // R3: every permutation with opaque layers, then a hidden layer
    base_cfg();
    lay_galpha = {3{12'hFFF}}; lay_amode = '0;
    for (int p = 0; p < 6; p++) begin
      int a0, a1;
      a0 = p / 2;
      a1 = (a0 + 1 + p % 2) % 3;
      lay_z = {2'(3 - a0 - a1), 2'(a1), 2'(a0)};
      cur_tag = "R3";
      rand_pix(); in_valid = 1'b1; lay_vld = 3'b111;
      issue();
      drain();
    end
    lay_z = {2'd3, 2'd1, 2'd0};
    cur_tag = "R3"; rand_pix(); in_valid = 1'b1; lay_vld = 3'b111; issue(); drain();

    // R4: shared code, lowest index wins
    lay_z = {2'd0, 2'd1, 2'd1};
    #1 chk("R4 cfg_err dup", 64'(cfg_err), 64'd1);
    cur_tag = "R4"; rand_pix(); in_valid = 1'b1; lay_vld = 3'b111; issue(); drain();
    run("R4", 20);
    lay_z = {2'd3, 2'd3, 2'd0};
    #1 chk("R4 cfg_err hidden dup", 64'(cfg_err), 64'd1);
    lay_z = {2'd1, 2'd0, 2'd2};
    #1 chk("R4 cfg_err distinct", 64'(cfg_err), 64'd0);

    // R5: each alpha mode
    for (int m = 0; m < 4; m++) begin
      base_cfg();
      lay_amode = {3{2'(m)}};
      run("R5", 40);
    end
    // R7: premultiplied input
    for (int m = 0; m < 3; m++) begin
      base_cfg();
      lay_amode = {3{2'(m)}}; lay_premul = 3'b111;
      run("R7", 40);
    end
    // R8: disabled layers
    base_cfg(); lay_en = 3'b000; run("R8", 20);
    base_cfg(); lay_en = 3'b101; run("R8", 20);
    // R9: source key on graphics only
    base_cfg(); srckey_en = 1'b1; run("R9", 60);
    base_cfg(); srckey_en = 1'b1; lay_galpha = {3{12'hFFF}}; lay_amode = '0;
    lay_z = {2'd0, 2'd1, 2'd2};
    cur_tag = "R9"; rand_pix(); in_valid = 1'b1; lay_vld = 3'b111;
    lay_pix[35:0] = srckey_rgb; lay_pix[48 +: 36] = srckey_rgb;
    issue(); drain();
    // R10: destination key
    base_cfg(); dstkey_en = 1'b1; run("R10", 60);
    base_cfg(); dstkey_en = 1'b1; lay_amode = '0; lay_galpha = {3{12'h800}};
    run("R10", 40);
    // R6: random configurations
    for (int b = 0; b < 40; b++) begin
      rand_cfg();
      run("R6", 40);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule